// File: doc/BRIEF.md
# Guarded Clock Source Switch Sequencer

This block holds the clock selection registers of a chip and runs the sequence that moves the system clock from its present source to a newly requested one. There are eight source codes. Software reaches the block through a byte-wide write port with a byte select. The two register bytes can be read at all times. Each byte accepts a data write only in the clock cycle that follows its own two-value key, sent in back-to-back cycles. Writes that arrive any other way are dropped.

Software requests a switch by setting the go bit. The sequencer compares the requested code with the current one. If they are equal it drops the request at once. Otherwise it clears the PLL-lock and clock-fail status and turns on the target source. It then waits for that source to be usable: crystal sources must deliver a full start-up count of target clock ticks, and PLL sources must report lock. When the wait ends it commits the new code and drops the go bit. The enable of the old source then falls. Two exceptions apply: the low-power RC stays on while the configuration asks for it, and the secondary oscillator stays on while its software enable is set.

The states are SQ_IDLE, SQ_CHECK, SQ_WAIT and SQ_COMMIT, with these transitions:
- start: SQ_IDLE to SQ_CHECK, when go is set.
- redundant: SQ_CHECK to SQ_IDLE, when the codes are equal.
- begin: SQ_CHECK to SQ_WAIT.
- cancel: SQ_CHECK or SQ_WAIT to SQ_IDLE, when go is cleared.
- abort: SQ_CHECK or SQ_WAIT to SQ_IDLE, when sleep is requested.
- ready: SQ_WAIT to SQ_COMMIT.
- finish: SQ_COMMIT to SQ_IDLE.

Top module: `clksw_ctrl`

## Requirements
- R1: The upper byte (`reg_hi`) accepts a write only when 0x78 and then 0x9A were written to it in the two cycles just before. Its field is bits [2:0], the requested source code. A write with no key has no effect.
- R2: The lower byte (`reg_lo`) needs the key 0x46 then 0x57, in that order. A key in the wrong order, or a key meant for the other byte, leaves the byte unchanged.
- R3: The write window lasts for exactly the one cycle after the second key value. A write in any later cycle is ignored.
- R4: After reset, `reg_hi` = 0x77 (current code 111 in bits [6:4], requested code 111 in bits [2:0]), `reg_lo` = 0x00, and `src_en` = 0x80.
- R5: If go (`reg_lo[0]`) is set while the requested code equals the current one, go clears. The current code and the status bits keep their values.
- R6: A non-redundant switch clears clock-fail (`reg_lo[3]`, set by `clk_fail`, cleared by writing 0 to it) and PLL-lock (`reg_lo[5]`). PLL-lock reads 1 only when the block is idle, the current source is a PLL code and `pll_lock` is high.
- R7: The crystal codes are 010, 011 and 100. A switch to one of them waits for OST_CYCLES (1024) pulses of `tgt_tick`. A pulse counts only while the target's `src_rdy` bit is high.
- R8: A switch to a PLL code (001 or 011) also waits for `pll_lock`. A switch to any other code waits for the `src_rdy` bit of the target.
- R9: On completion, the current code becomes the target code, go clears, and `src_en` keeps only the current source. Bit 5 (101, low-power RC) also stays on while `cfg_lprc_hold` is high. Bit 4 (100, secondary) also stays on while `reg_lo[1]` is set.
- R10: Clearing go during a switch abandons it and keeps the current code. The next switch starts the start-up count again from zero.
- R11: A `sleep_req` pulse during a switch aborts it, clears go and keeps the current code.
- R12: While `cfg_switch_en` is low, go stays 0. While it is high, a set lock bit (`reg_lo[7]`) stops go from being set. The lock bit can only be set by a write; only reset clears it.
- R13: A target that never becomes ready leaves the block waiting indefinitely, with go still 1 and the current code unchanged.
- R14: Writes to the current-code field and to unused bits have no effect. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_sel_hi | input | 1 | 1 selects the upper byte, 0 the lower byte |
| bus_wdata | input | 8 | Write data |
| reg_hi | output | 8 | Upper byte: current code [6:4], requested code [2:0] |
| reg_lo | output | 8 | Lower byte: lock [7], PLL-lock [5], clock-fail [3], secondary enable [1], go [0] |
| cfg_switch_en | input | 1 | Configuration: switching allowed |
| cfg_lprc_hold | input | 1 | Configuration: keep low-power RC on (watchdog or fail monitor in use) |
| sleep_req | input | 1 | Sleep entry pulse |
| clk_fail | input | 1 | Clock-failure detect pulse |
| tgt_tick | input | 1 | One pulse per cycle of the target clock model |
| pll_lock | input | 1 | PLL lock indication |
| src_rdy | input | 8 | Ready flag for each source code |
| src_en | output | 8 | Enable for each source code |

## Verification
The assertions assume that `src_rdy`, `pll_lock` and `tgt_tick` come from well-behaved oscillator models. They also assume that `clk_fail` and `sleep_req` are single-cycle pulses and that the bus carries at most one write per cycle. The stimulus drives every input on the falling edge. It holds `tgt_tick` high, so each cycle is one target tick. It changes ready and lock levels only between switches, or in the middle of a wait when the scenario tests that wait. Each key sequence goes through a task that drives three back-to-back write cycles.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
    localparam logic [2:0] SRC_FRC     = 3'b000;
    localparam logic [2:0] SRC_FRC_PLL = 3'b001;
    localparam logic [2:0] SRC_PRI     = 3'b010;
    localparam logic [2:0] SRC_PRI_PLL = 3'b011;
    localparam logic [2:0] SRC_SEC     = 3'b100;
    localparam logic [2:0] SRC_LPRC    = 3'b101;
    localparam logic [2:0] SRC_FRC_DIV = 3'b111;

    localparam int NUM_SRC = 8;

    typedef enum logic [1:0] {SQ_IDLE, SQ_CHECK, SQ_WAIT, SQ_COMMIT} seq_state_t;
    typedef enum logic [1:0] {UK_IDLE, UK_KEY1, UK_OPEN} key_state_t;

    function automatic logic is_xtal(input logic [2:0] s);
        return (s == SRC_PRI) || (s == SRC_PRI_PLL) || (s == SRC_SEC);
    endfunction

    function automatic logic is_pll(input logic [2:0] s);
        return (s == SRC_FRC_PLL) || (s == SRC_PRI_PLL);
    endfunction

    // key values: index 0 = lower byte, 1 = upper byte
    function automatic logic [7:0] key_first(input int b);
        return (b == 1) ? 8'h78 : 8'h46;
    endfunction

    function automatic logic [7:0] key_second(input int b);
        return (b == 1) ? 8'h9A : 8'h57;
    endfunction
endpackage

// File: rtl/clksw_unlock.sv
module clksw_unlock #(
    parameter logic [7:0] KEY_A = 8'h00,
    parameter logic [7:0] KEY_B = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       open_win
);
    import clksw_pkg::*;

    key_state_t st, st_nx;

    always_comb begin
        if (st == UK_KEY1 && wr && wdata == KEY_B)
            st_nx = UK_OPEN;
        else if (wr && wdata == KEY_A)
            st_nx = UK_KEY1;
        else
            st_nx = UK_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= UK_IDLE;
        else        st <= st_nx;
    end

    assign open_win = (st == UK_OPEN);

    // R1
    open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == UK_OPEN) |-> $past(wr && wdata == KEY_B));
endmodule

// File: rtl/clksw_ost.sv
module clksw_ost #(
    parameter int CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] LIMIT = W'(CYCLES);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (clr)                    cnt <= '0;
        else if (tick && cnt != LIMIT)   cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIMIT);

    // R7
    ost_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !clr |=> done);
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       sleep,
    input  logic       ready,
    input  logic [2:0] req_sel,
    input  logic [2:0] cur_sel,
    output logic [2:0] tgt,
    output logic       busy,
    output logic       checking,
    output logic       go_clr,
    output logic       sts_clr,
    output logic       ost_clr,
    output logic       commit
);
    import clksw_pkg::*;

    seq_state_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            tgt <= SRC_FRC_DIV;
        end else begin
            st <= st_nx;
            if (st == SQ_IDLE && go) tgt <= req_sel;
        end
    end

    always_comb begin
        st_nx   = st;
        go_clr  = 1'b0;
        sts_clr = 1'b0;
        ost_clr = 1'b0;
        commit  = 1'b0;
        unique case (st)
            SQ_IDLE: if (go) st_nx = SQ_CHECK;
            SQ_CHECK: begin
                if (sleep || !go) begin
                    st_nx   = SQ_IDLE;
                    go_clr  = sleep;
                    ost_clr = 1'b1;
                end else if (tgt == cur_sel) begin
                    st_nx  = SQ_IDLE;
                    go_clr = 1'b1;
                end else begin
                    st_nx   = SQ_WAIT;
                    sts_clr = 1'b1;
                    ost_clr = 1'b1;
                end
            end
            SQ_WAIT: begin
                if (sleep || !go) begin
                    st_nx   = SQ_IDLE;
                    go_clr  = sleep;
                    ost_clr = 1'b1;
                end else if (ready) begin
                    st_nx = SQ_COMMIT;
                end
            end
            SQ_COMMIT: begin
                st_nx  = SQ_IDLE;
                commit = 1'b1;
                go_clr = 1'b1;
            end
            default: st_nx = SQ_IDLE;
        endcase
    end

    assign busy     = (st != SQ_IDLE);
    assign checking = (st == SQ_CHECK);

    // R11
    sleep_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_CHECK || st == SQ_WAIT) && sleep |=> st == SQ_IDLE);

    // R13
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == SQ_WAIT && go && !sleep && !ready |=> st == SQ_WAIT);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl #(
    parameter int OST_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic       bus_sel_hi,
    input  logic [7:0] bus_wdata,
    output logic [7:0] reg_hi,
    output logic [7:0] reg_lo,
    input  logic       cfg_switch_en,
    input  logic       cfg_lprc_hold,
    input  logic       sleep_req,
    input  logic       clk_fail,
    input  logic       tgt_tick,
    input  logic       pll_lock,
    input  logic [7:0] src_rdy,
    output logic [7:0] src_en
);
    import clksw_pkg::*;

    logic [1:0] open_win;
    logic       hi_acc, lo_acc;
    logic [2:0] cur_sel, new_sel, seq_tgt;
    logic       lock_bit, lock_sts, fail_flag, sec_en, sw_go;
    logic       seq_busy, seq_checking, seq_go_clr, seq_sts_clr, seq_ost_clr, seq_commit;
    logic       ost_done, tgt_ready;
    logic       unused_wbits;

    assign unused_wbits = ^{bus_wdata[6:4], bus_wdata[2]};

    for (genvar b = 0; b < 2; b++) begin : g_key
        logic byte_wr;
        assign byte_wr = bus_we && (bus_sel_hi == (b == 1));
        clksw_unlock #(.KEY_A(key_first(b)), .KEY_B(key_second(b))) u_key (
            .clk(clk), .rst_n(rst_n), .wr(byte_wr), .wdata(bus_wdata),
            .open_win(open_win[b])
        );
    end

    assign hi_acc = open_win[1] && bus_we &&  bus_sel_hi;
    assign lo_acc = open_win[0] && bus_we && !bus_sel_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_sel  <= SRC_FRC_DIV;
            cur_sel  <= SRC_FRC_DIV;
            lock_bit <= 1'b0;
            sec_en   <= 1'b0;
        end else begin
            if (hi_acc) new_sel <= bus_wdata[2:0];
            if (lo_acc) begin
                lock_bit <= lock_bit | bus_wdata[7];
                sec_en   <= bus_wdata[1];
            end
            if (seq_commit) cur_sel <= seq_tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        sw_go <= 1'b0;
        else if (!cfg_switch_en)           sw_go <= 1'b0;
        else if (seq_go_clr)               sw_go <= 1'b0;
        else if (lo_acc) begin
            if (!bus_wdata[0])             sw_go <= 1'b0;
            else if (!lock_bit)            sw_go <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_flag <= 1'b0;
            lock_sts  <= 1'b0;
        end else begin
            if (seq_sts_clr)                   fail_flag <= 1'b0;
            else if (clk_fail)                 fail_flag <= 1'b1;
            else if (lo_acc && !bus_wdata[3])  fail_flag <= 1'b0;

            if (seq_sts_clr)                   lock_sts <= 1'b0;
            else if (!seq_busy)                lock_sts <= pll_lock && is_pll(cur_sel);
        end
    end

    always_comb begin
        tgt_ready = is_xtal(seq_tgt) ? ost_done : src_rdy[seq_tgt];
        if (is_pll(seq_tgt)) tgt_ready = tgt_ready && pll_lock;
    end

    clksw_ost #(.CYCLES(OST_CYCLES)) u_ost (
        .clk(clk), .rst_n(rst_n), .clr(seq_ost_clr),
        .tick(tgt_tick && src_rdy[seq_tgt] && seq_busy), .done(ost_done)
    );

    clksw_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(sw_go), .sleep(sleep_req), .ready(tgt_ready),
        .req_sel(new_sel), .cur_sel(cur_sel), .tgt(seq_tgt), .busy(seq_busy),
        .checking(seq_checking), .go_clr(seq_go_clr), .sts_clr(seq_sts_clr),
        .ost_clr(seq_ost_clr), .commit(seq_commit)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_en
        always_comb begin
            src_en[s] = (cur_sel == 3'(s)) || (seq_busy && seq_tgt == 3'(s));
            if (s == int'(SRC_LPRC)) src_en[s] = src_en[s] || cfg_lprc_hold;
            if (s == int'(SRC_SEC))  src_en[s] = src_en[s] || sec_en;
        end
    end

    assign reg_hi = {1'b0, cur_sel, 1'b0, new_sel};
    assign reg_lo = {lock_bit, 1'b0, lock_sts, 1'b0, fail_flag, 1'b0, sec_en, sw_go};

    // R5
    redundant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_checking && sw_go && !sleep_req && seq_tgt == cur_sel
        |=> !sw_go && cur_sel == $past(cur_sel) && !seq_busy);

    // R9
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_commit |=> cur_sel == $past(seq_tgt) && !sw_go);

    // R12
    switch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_switch_en |=> !sw_go);

    // R6
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_sts_clr |=> !fail_flag && !lock_sts);
endmodule

// File: tb/clksw_ctrl_test.sv
module clksw_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0, bus_sel_hi = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] reg_hi, reg_lo, src_en;
    logic       cfg_switch_en = 1'b1, cfg_lprc_hold = 1'b0;
    logic       sleep_req = 1'b0, clk_fail = 1'b0;
    logic       tgt_tick = 1'b1, pll_lock = 1'b1;
    logic [7:0] src_rdy = 8'hFF;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    clksw_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel_hi(bus_sel_hi),
        .bus_wdata(bus_wdata), .reg_hi(reg_hi), .reg_lo(reg_lo),
        .cfg_switch_en(cfg_switch_en), .cfg_lprc_hold(cfg_lprc_hold),
        .sleep_req(sleep_req), .clk_fail(clk_fail), .tgt_tick(tgt_tick),
        .pll_lock(pll_lock), .src_rdy(src_rdy), .src_en(src_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit hi, input logic [7:0] d);
        @(negedge clk); bus_we = 1'b1; bus_sel_hi = hi; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic uwr(input bit hi, input logic [7:0] d);
        @(negedge clk); bus_we = 1'b1; bus_sel_hi = hi; bus_wdata = hi ? 8'h78 : 8'h46;
        @(negedge clk); bus_wdata = hi ? 8'h9A : 8'h57;
        @(negedge clk); bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        for (int i = 0; i < lim && reg_lo[0]; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        idle(2);
        chk("R4 hi", reg_hi, 8'h77);
        chk("R4 lo", reg_lo, 8'h00);
        chk("R4 en", src_en, 8'h80);
    endtask

    task automatic t_keys;
        wr(1'b1, 8'h00);
        chk("R1 no key", reg_hi, 8'h77);
        uwr(1'b1, 8'hF0);
        chk("R14 cur field", reg_hi, 8'h70);
        @(negedge clk); bus_we = 1'b1; bus_sel_hi = 1'b0; bus_wdata = 8'h57;
        @(negedge clk); bus_wdata = 8'h46;
        @(negedge clk); bus_wdata = 8'h02;
        @(negedge clk); bus_we = 1'b0;
        chk("R2 order", reg_lo, 8'h00);
        @(negedge clk); bus_we = 1'b1; bus_sel_hi = 1'b0; bus_wdata = 8'h78;
        @(negedge clk); bus_wdata = 8'h9A;
        @(negedge clk); bus_wdata = 8'h02;
        @(negedge clk); bus_we = 1'b0;
        chk("R2 other key", reg_lo, 8'h00);
        @(negedge clk); bus_we = 1'b1; bus_sel_hi = 1'b1; bus_wdata = 8'h78;
        @(negedge clk); bus_wdata = 8'h9A;
        @(negedge clk); bus_we = 1'b0;
        @(negedge clk); bus_we = 1'b1; bus_wdata = 8'h05;
        @(negedge clk); bus_we = 1'b0;
        chk("R3 late write", reg_hi, 8'h70);
    endtask

    task automatic t_redundant;
        uwr(1'b1, 8'h07);
        @(negedge clk); clk_fail = 1'b1;
        @(negedge clk); clk_fail = 1'b0;
        chk("R6 fail set", reg_lo, 8'h08);
        uwr(1'b0, 8'h09);
        idle(4);
        chk("R5 go", reg_lo, 8'h08);
        chk("R5 cur", reg_hi, 8'h77);
        chk("R5 en", src_en, 8'h80);
    endtask

    task automatic t_plain;
        uwr(1'b1, 8'h00);
        uwr(1'b0, 8'h09);
        wait_done(50);
        chk("R8 cur", reg_hi, 8'h00);
        chk("R6 status", reg_lo, 8'h00);
        chk("R9 en", src_en, 8'h01);
    endtask

    task automatic t_pll;
        pll_lock = 1'b0;
        uwr(1'b1, 8'h01);
        uwr(1'b0, 8'h01);
        idle(50);
        chk("R13 go held", reg_lo, 8'h01);
        chk("R13 cur", reg_hi, 8'h01);
        pll_lock = 1'b1;
        wait_done(20);
        idle(2);
        chk("R8 pll cur", reg_hi, 8'h11);
        chk("R6 lock sts", reg_lo, 8'h20);
    endtask

    task automatic t_crystal;
        uwr(1'b1, 8'h02);
        uwr(1'b0, 8'h01);
        idle(600);
        chk("R7 still waiting", reg_lo, 8'h01);
        chk("R7 en", src_en, 8'h06);
        wait_done(700);
        idle(2);
        chk("R7 cur", reg_hi, 8'h22);
        chk("R9 en", src_en, 8'h04);
    endtask

    task automatic t_cancel;
        uwr(1'b1, 8'h04);
        uwr(1'b0, 8'h03);
        idle(800);
        uwr(1'b0, 8'h02);
        idle(3);
        chk("R10 go", reg_lo, 8'h02);
        chk("R10 cur", reg_hi, 8'h24);
        uwr(1'b0, 8'h03);
        idle(600);
        chk("R10 restart", reg_lo, 8'h03);
        wait_done(700);
        idle(2);
        chk("R10 done", reg_hi, 8'h44);
        uwr(1'b1, 8'h05);
        uwr(1'b0, 8'h03);
        wait_done(50);
        idle(2);
        chk("R9 sec hold", src_en, 8'h30);
        cfg_lprc_hold = 1'b1;
        uwr(1'b1, 8'h00);
        uwr(1'b0, 8'h01);
        wait_done(50);
        idle(2);
        chk("R9 lprc hold", src_en, 8'h21);
    endtask

    task automatic t_sleep;
        src_rdy = 8'hEF;
        uwr(1'b1, 8'h04);
        uwr(1'b0, 8'h01);
        idle(10);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        idle(3);
        chk("R11 go", reg_lo, 8'h00);
        chk("R11 cur", reg_hi, 8'h04);
        src_rdy = 8'hFF;
    endtask

    task automatic t_lockout;
        cfg_switch_en = 1'b0;
        uwr(1'b1, 8'h02);
        uwr(1'b0, 8'h01);
        idle(20);
        chk("R12 disabled go", reg_lo, 8'h00);
        chk("R12 disabled cur", reg_hi, 8'h02);
        cfg_switch_en = 1'b1;
        uwr(1'b0, 8'h80);
        uwr(1'b0, 8'h01);
        idle(20);
        chk("R12 locked go", reg_lo, 8'h80);
        chk("R12 locked cur", reg_hi, 8'h02);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset;
        t_keys;
        t_redundant;
        t_plain;
        t_pll;
        t_crystal;
        t_cancel;
        t_sleep;
        t_lockout;
        finish_run;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule